// File: doc/BRIEF.md
# Read Strobe Offset Calibration Engine

This engine tunes the read-strobe delay of a memory channel that is built from byte lanes, four by default. Every lane has its own signed delay offset. All lane offsets sit in one combined offset word, with one byte per lane. After a start pulse the engine latches a coarse DLL lock value and a channel number. It then sweeps each lane's offset across a window that the lock value sets. Every trial offset is written to the offset register and followed by a one-cycle resync pulse, so that the slave delay line picks up the new value. The engine then reads known test words back from memory and compares only the byte of the lane under test.

The sweep runs in two passes. The first pass climbs from the low limit towards the high limit. The second pass descends from the high limit towards the low limit. Each pass keeps the first offset that passes. Each lane is then centred on the midpoint of the two edges it found. The encoded midpoints are written as one final offset word, followed by a last resync pulse. The final word stays on an output until the next calibration completes. The caller must store the four test words in memory before starting the engine.

The controller is a single state machine:
- IDLE waits for start.
- LANE_LOAD writes the all-default word and goes to LANE_SYNC.
- LANE_SYNC pulses resync and goes to STEP_LOAD.
- STEP_LOAD writes the trial word and goes to STEP_SYNC.
- STEP_SYNC pulses resync and goes to RD_ISSUE.
- RD_ISSUE holds a read request until it is accepted, then goes to RD_WAIT.
- RD_WAIT takes the response and goes:
  - to RD_ISSUE for the next word;
  - to STEP_LOAD for the next offset;
  - to LANE_END when the step passes or the sweep is exhausted.
- LANE_END moves to the next lane or pass (back to LANE_LOAD), or to FINAL_LOAD after the last lane of the descending pass.
- FINAL_LOAD writes the centred word and goes to FINAL_SYNC.
- FINAL_SYNC pulses resync and goes to FINISH.
- FINISH raises done for one cycle and returns to IDLE.

Top module: `rdqs_window_cal`

## Requirements
- R1: While reset is applied and afterwards until a start, busy, done, ofs_we, resync and rd_req_valid are low and ofs_final is zero.
- R2: Lane n of every offset word uses bits 8n+7..8n in sign-magnitude form. Bit 7 is the sign (1 = negative) and bits 6..0 are the magnitude. A zero value is always written with the sign bit clear.
- R3: The low sweep limit is 8 minus the coarse value. The high sweep limit is 8 plus the coarse value, clamped to at most 127.
- R4: For every lane, the ascending pass tries offsets from the low limit up to the high limit, inclusive, and keeps the first that passes. The descending pass tries offsets from the high limit down to the low limit, inclusive, and keeps the first that passes. A pass that finds nothing leaves that edge at 8. All lanes run the ascending pass before any lane runs the descending pass, and lanes go in ascending order.
- R5: Before each lane's sweep in each pass, the engine writes an offset word with every lane set to 8 (0x08 per byte).
- R6: Each trial writes a word in which every lane holds 8 except the lane under test, which holds the trial offset. Every offset-register write is followed in the very next cycle by a one-cycle resync pulse, and resync is never high otherwise.
- R7: A trial reads word k (k = 0..3, in that order) at base + channel × 0x80 + 4k. It compares the lane's byte with 0x5A, 0xA5, 0xF0 and 0x0F respectively. Only one read is outstanding at a time, and a request holds its valid and address until it is accepted.
- R8: A trial fails on the first mismatching word, and the engine issues no further reads for that trial. A trial passes only after all four words match.
- R9: Each lane's final offset is the sum of its two edges divided by 2, truncated toward zero. The centred word is written exactly once at the end, followed by a resync pulse, and is presented on ofs_final.
- R10: busy rises the cycle after start and stays high through the single cycle in which done is high. done lasts one cycle. A start while busy has no effect.
- R11: ofs_final keeps its value while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration (sampled when idle) |
| coarse | input | COARSE_W | Coarse DLL lock value, latched at start |
| chan | input | CH_W | Channel number that selects the test address block |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | One-cycle completion pulse |
| ofs_we | output | 1 | Offset-register write strobe |
| ofs_wdata | output | 8×LANES | Offset word to write |
| resync | output | 1 | Delay-line resync pulse |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 8×LANES | Read data |
| ofs_final | output | 8×LANES | Last centred offset word |

## Verification
The bench models memory whose lane bytes read correctly only while that lane's decoded offset lies inside a per-lane window. A failing offset corrupts one chosen word. A design that compared the full word, and not just the lane byte, would fail lanes whose neighbours sit outside their windows at 8. A design without early exit would issue more reads than the model predicts. The directed cases cover:
- a lock value of 0, where both limits equal 8;
- a lock value of 127, where a window reaching past 127 shifts the centre if the clamp is missing;
- empty windows, which must leave both edges at 8;
- an odd negative edge sum, where flooring instead of truncating gives 0x86 instead of 0x85;
- an edge sum of -1, which must encode as 0x00 and not as negative zero.

A start pulse in mid-run checks that the engine does not restart, since a restart would change the count of writes.

// File: rtl/rdw_pkg.sv
package rdw_pkg;

    localparam int LANE_BITS = 8;
    localparam int NUM_WORDS = 4;
    localparam int WORD_W    = 2;

    // signed trial offset, wide enough for both limits and their sum halves
    typedef logic signed [8:0] ofs_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LANE_LOAD,
        ST_LANE_SYNC,
        ST_STEP_LOAD,
        ST_STEP_SYNC,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_LANE_END,
        ST_FINAL_LOAD,
        ST_FINAL_SYNC,
        ST_FINISH
    } cal_state_e;

    // sign-magnitude byte: bit 7 sign, bits 6..0 magnitude
    function automatic logic [7:0] sm_encode(input ofs_t v);
        return v[8] ? {1'b1, 7'(-v)} : {1'b0, v[6:0]};
    endfunction

    // expected byte of test word idx in every lane
    function automatic logic [7:0] pattern_byte(input logic [WORD_W-1:0] idx);
        case (idx)
            2'd0:    return 8'h5A;
            2'd1:    return 8'hA5;
            2'd2:    return 8'hF0;
            default: return 8'h0F;
        endcase
    endfunction

endpackage

// File: rtl/rdw_lane_cmp.sv
module rdw_lane_cmp
    import rdw_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LW    = 2
) (
    input  logic [LANES*LANE_BITS-1:0] rsp_data,
    input  logic [WORD_W-1:0]          word_idx,
    input  logic [LW-1:0]              lane,
    output logic                       match
);

    logic [LANES-1:0] hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit[g] = (rsp_data[g*LANE_BITS +: LANE_BITS] == pattern_byte(word_idx));
    end

    assign match = hit[lane];

endmodule

// File: rtl/rdw_center.sv
module rdw_center
    import rdw_pkg::*;
#(
    parameter int LANES = 4
) (
    input  ofs_t                       lo_edge [LANES],
    input  ofs_t                       hi_edge [LANES],
    output logic [LANES*LANE_BITS-1:0] code_word
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [9:0] sum;
        logic        [9:0] mag;
        logic        [6:0] half;

        assign sum  = {lo_edge[g][8], lo_edge[g]} + {hi_edge[g][8], hi_edge[g]};
        assign mag  = sum[9] ? 10'(-sum) : 10'(sum);
        // halving the magnitude truncates toward zero for either sign
        assign half = 7'(mag >> 1);
        assign code_word[g*LANE_BITS +: LANE_BITS] = {sum[9] && (half != 7'd0), half};
    end

endmodule

// File: rtl/rdqs_window_cal.sv
module rdqs_window_cal
    import rdw_pkg::*;
#(
    parameter int                LANES     = 4,
    parameter int                ADDR_W    = 32,
    parameter int                CH_W      = 1,
    parameter int                COARSE_W  = 7,
    parameter int                DEF_OFS   = 8,
    parameter int                MAX_OFS   = 127,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [ADDR_W-1:0] CH_STRIDE = 'h80
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [COARSE_W-1:0]        coarse,
    input  logic [CH_W-1:0]            chan,
    output logic                       busy,
    output logic                       done,
    output logic                       ofs_we,
    output logic [LANES*LANE_BITS-1:0] ofs_wdata,
    output logic                       resync,
    output logic                       rd_req_valid,
    input  logic                       rd_req_ready,
    output logic [ADDR_W-1:0]          rd_req_addr,
    input  logic                       rd_rsp_valid,
    input  logic [LANES*LANE_BITS-1:0] rd_rsp_data,
    output logic [LANES*LANE_BITS-1:0] ofs_final
);

    localparam int DW        = LANES * LANE_BITS;
    localparam int LW        = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int LAST_WORD = NUM_WORDS - 1;
    localparam logic [LANE_BITS-1:0] DEF_CODE = LANE_BITS'(DEF_OFS);
    localparam logic [DW-1:0]        DEF_WORD = {LANES{DEF_CODE}};

    cal_state_e state_q, state_d;

    logic [COARSE_W-1:0] coarse_q;
    logic [CH_W-1:0]     chan_q;
    logic [LW-1:0]       lane_q;
    logic                pass_q;      // 0: ascending, 1: descending
    logic [WORD_W-1:0]   word_q;
    ofs_t                shift_q;
    ofs_t                left_q  [LANES];
    ofs_t                right_q [LANES];
    logic [DW-1:0]       final_q;

    ofs_t          coarse_s, hi_sum, lo_lim, hi_lim, sweep_first, sweep_last;
    logic          word_ok, lane_last, at_end;
    logic [DW-1:0] step_word, center_word;

    // ---------------- sweep limits ----------------
    always_comb begin
        coarse_s    = ofs_t'(coarse_q);
        lo_lim      = ofs_t'(DEF_OFS) - coarse_s;
        hi_sum      = ofs_t'(DEF_OFS) + coarse_s;
        hi_lim      = (hi_sum > ofs_t'(MAX_OFS)) ? ofs_t'(MAX_OFS) : hi_sum;
        sweep_first = pass_q ? hi_lim : lo_lim;
        sweep_last  = pass_q ? lo_lim : hi_lim;
        at_end      = (shift_q == sweep_last);
        lane_last   = (lane_q == LW'(LANES - 1));
    end

    // trial word: defaults everywhere except the lane being swept
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            step_word[i*LANE_BITS +: LANE_BITS] =
                (LW'(i) == lane_q) ? sm_encode(shift_q) : DEF_CODE;
        end
    end

    rdw_lane_cmp #(
        .LANES (LANES),
        .LW    (LW)
    ) u_cmp (
        .rsp_data (rd_rsp_data),
        .word_idx (word_q),
        .lane     (lane_q),
        .match    (word_ok)
    );

    rdw_center #(
        .LANES (LANES)
    ) u_center (
        .lo_edge   (left_q),
        .hi_edge   (right_q),
        .code_word (center_word)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start) state_d = ST_LANE_LOAD;
            ST_LANE_LOAD:  state_d = ST_LANE_SYNC;
            ST_LANE_SYNC:  state_d = ST_STEP_LOAD;
            ST_STEP_LOAD:  state_d = ST_STEP_SYNC;
            ST_STEP_SYNC:  state_d = ST_RD_ISSUE;
            ST_RD_ISSUE:   if (rd_req_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: begin
                if (rd_rsp_valid) begin
                    if (!word_ok)
                        state_d = at_end ? ST_LANE_END : ST_STEP_LOAD;
                    else if (word_q == WORD_W'(LAST_WORD))
                        state_d = ST_LANE_END;
                    else
                        state_d = ST_RD_ISSUE;
                end
            end
            ST_LANE_END:   state_d = (lane_last && pass_q) ? ST_FINAL_LOAD : ST_LANE_LOAD;
            ST_FINAL_LOAD: state_d = ST_FINAL_SYNC;
            ST_FINAL_SYNC: state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coarse_q <= '0;
            chan_q   <= '0;
            lane_q   <= '0;
            pass_q   <= 1'b0;
            word_q   <= '0;
            shift_q  <= '0;
            final_q  <= '0;
            for (int i = 0; i < LANES; i++) begin
                left_q[i]  <= ofs_t'(DEF_OFS);
                right_q[i] <= ofs_t'(DEF_OFS);
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        coarse_q <= coarse;
                        chan_q   <= chan;
                        lane_q   <= '0;
                        pass_q   <= 1'b0;
                    end
                end
                ST_LANE_LOAD: begin
                    shift_q <= sweep_first;
                    if (pass_q) right_q[lane_q] <= ofs_t'(DEF_OFS);
                    else        left_q[lane_q]  <= ofs_t'(DEF_OFS);
                end
                ST_STEP_LOAD: word_q <= '0;
                ST_RD_WAIT: begin
                    if (rd_rsp_valid) begin
                        if (!word_ok) begin
                            if (!at_end)
                                shift_q <= pass_q ? shift_q - ofs_t'(1) : shift_q + ofs_t'(1);
                        end else if (word_q == WORD_W'(LAST_WORD)) begin
                            if (pass_q) right_q[lane_q] <= shift_q;
                            else        left_q[lane_q]  <= shift_q;
                        end else begin
                            word_q <= word_q + WORD_W'(1);
                        end
                    end
                end
                ST_LANE_END: begin
                    if (lane_last) begin
                        lane_q <= '0;
                        pass_q <= 1'b1;
                    end else begin
                        lane_q <= lane_q + LW'(1);
                    end
                end
                ST_FINAL_LOAD: final_q <= center_word;
                default: ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy         = 1'b1;
        done         = 1'b0;
        ofs_we       = 1'b0;
        ofs_wdata    = step_word;
        resync       = 1'b0;
        rd_req_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:       busy = 1'b0;
            ST_LANE_LOAD:  begin ofs_we = 1'b1; ofs_wdata = DEF_WORD;    end
            ST_STEP_LOAD:  ofs_we = 1'b1;
            ST_FINAL_LOAD: begin ofs_we = 1'b1; ofs_wdata = center_word; end
            ST_LANE_SYNC, ST_STEP_SYNC, ST_FINAL_SYNC: resync = 1'b1;
            ST_RD_ISSUE:   rd_req_valid = 1'b1;
            ST_FINISH:     done = 1'b1;
            default: ;
        endcase
    end

    assign rd_req_addr = BASE_ADDR + ADDR_W'(chan_q) * CH_STRIDE
                       + ADDR_W'(word_q) * ADDR_W'(LANES);
    assign ofs_final   = final_q;

    // ---------------- assertions ----------------
    p_sync_follows_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_we |=> resync);

    p_sync_only_after_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> $past(ofs_we));

    p_req_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_final_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(ofs_final));

endmodule

// File: tb/test_rdqs_window_cal.sv
`timescale 1ns/1ps
module test_rdqs_window_cal;

    localparam int          LANES = 4;
    localparam logic [31:0] BASE  = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  coarse = '0;
    logic [0:0]  chan = '0;
    logic        busy, done, ofs_we, resync, rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [31:0] ofs_wdata, rd_req_addr, ofs_final;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;

    always #4 clk = ~clk;

    rdqs_window_cal #(
        .LANES(LANES), .ADDR_W(32), .CH_W(1), .COARSE_W(7), .DEF_OFS(8),
        .MAX_OFS(127), .BASE_ADDR(BASE), .CH_STRIDE(32'h80)
    ) i_rdqs_window_cal (
        .clk(clk), .rst_n(rst_n), .start(start), .coarse(coarse), .chan(chan),
        .busy(busy), .done(done), .ofs_we(ofs_we), .ofs_wdata(ofs_wdata),
        .resync(resync), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
        .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .ofs_final(ofs_final)
    );

    int n_vec = 0, n_bad = 0;
    int win_lo[LANES], win_hi[LANES];
    int fail_word = 0;
    logic [31:0] cur_ofs = 32'h0;
    int wr_cnt = 0, rd_cnt = 0, rs_err = 0, addr_err = 0, rd_since_wr = 0;

    function automatic logic [7:0] pat_byte(int k);
        case (k)
            0: return 8'h5A;
            1: return 8'hA5;
            2: return 8'hF0;
            default: return 8'h0F;
        endcase
    endfunction

    function automatic int dec(logic [7:0] b);
        return b[7] ? -int'(b[6:0]) : int'(b[6:0]);
    endfunction

    function automatic logic [7:0] enc(int v);
        logic [7:0] r;
        if (v < 0) r = 8'h80 | 8'(-v);
        else       r = 8'(v);
        return r;
    endfunction

    function automatic bit inwin(int l, int v);
        return (v >= win_lo[l]) && (v <= win_hi[l]);
    endfunction

    function automatic logic [31:0] mkdata(int k);
        logic [31:0] d;
        for (int l = 0; l < LANES; l++) begin
            logic [7:0] b;
            b = pat_byte(k);
            if (k == fail_word && !inwin(l, dec(cur_ofs[8*l +: 8]))) b = b ^ 8'hFF;
            d[8*l +: 8] = b;
        end
        return d;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // reference of the search, built from the requirements
    task automatic model(input int c, output logic [31:0] w, output int nw, output int nr);
        int lo, hi;
        int le[LANES], re[LANES];
        lo = 8 - c;
        hi = 8 + c;
        if (hi > 127) hi = 127;
        nw = 0;
        nr = 0;
        for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < LANES; l++) begin
                int s, e, inc, r;
                r = 8;
                nw++;
                s = p ? hi : lo;
                e = p ? lo : hi;
                inc = p ? -1 : 1;
                forever begin
                    nw++;
                    if (inwin(l, s)) begin
                        nr += 4;
                        r = s;
                        break;
                    end
                    nr += fail_word + 1;
                    if (s == e) break;
                    s += inc;
                end
                if (p == 0) le[l] = r;
                else        re[l] = r;
            end
        end
        nw++;
        for (int l = 0; l < LANES; l++) w[8*l +: 8] = enc((le[l] + re[l]) / 2);
    endtask

    // memory responder and port monitor, all at the falling edge
    initial begin
        bit lv = 0, lr = 0, pend = 0, prev_we = 0;
        logic [31:0] la = '0;
        int dly = 0, pk = 0;
        forever begin
            @(negedge clk);
            rd_rsp_valid = 1'b0;
            if (!rst_n) begin
                lv = 0; lr = 0; pend = 0; prev_we = 0;
                rd_req_ready = 1'b0;
                continue;
            end
            if (lv && lr) begin
                pend = 1;
                dly = $urandom_range(0, 3);
                if (la != BASE + 32'(chan) * 32'h80 + 32'(4 * rd_since_wr)) addr_err++;
                pk = rd_since_wr;
                rd_since_wr++;
                rd_cnt++;
            end
            if (rd_req_valid && pend) addr_err++;
            if (prev_we != resync) rs_err++;
            prev_we = ofs_we;
            if (ofs_we) begin
                cur_ofs = ofs_wdata;
                wr_cnt++;
                rd_since_wr = 0;
            end
            if (pend) begin
                if (dly == 0) begin
                    rd_rsp_valid = 1'b1;
                    rd_rsp_data = mkdata(pk);
                    pend = 0;
                end else begin
                    dly--;
                end
            end
            rd_req_ready = 1'($urandom_range(0, 1));
            lv = rd_req_valid;
            lr = rd_req_ready;
            la = rd_req_addr;
        end
    end

    task automatic run_case(input int c, input bit chv, input int fw, input bit poke);
        logic [31:0] ew;
        int ewr, erd, t;
        fail_word = fw;
        model(c, ew, ewr, erd);
        wr_cnt = 0; rd_cnt = 0; rs_err = 0; addr_err = 0;
        @(negedge clk);
        coarse = 7'(c);
        chan = chv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
        t = 0;
        while (done !== 1'b1 && t < 60000) begin
            @(negedge clk);
            t++;
            start = (poke && (t == 20 || t == 21)) ? 1'b1 : 1'b0;
        end
        start = 1'b0;
        chk(t < 60000, "R10", "done reached", 32'(t), 32'd0);
        chk(busy === 1'b1, "R10", "busy during done", 32'(busy), 32'd1);
        chk(ofs_final === ew, "R2 R9", "centred offset word", ofs_final, ew);
        chk(cur_ofs === ew, "R9", "last written word", cur_ofs, ew);
        chk(wr_cnt == ewr, "R3 R4 R5", "offset writes", 32'(wr_cnt), 32'(ewr));
        chk(rd_cnt == erd, "R7 R8", "reads issued", 32'(rd_cnt), 32'(erd));
        chk(addr_err == 0, "R7", "address/outstanding errors", 32'(addr_err), 32'd0);
        chk(rs_err == 0, "R6", "resync pairing errors", 32'(rs_err), 32'd0);
        @(negedge clk);
        chk(done === 1'b0, "R10", "done one cycle", 32'(done), 32'd0);
        chk(busy === 1'b0, "R10", "busy dropped", 32'(busy), 32'd0);
        repeat (10) @(negedge clk);
        chk(ofs_final === ew, "R11", "final word held", ofs_final, ew);
    endtask

    task automatic set_win(input int l, input int lo, input int hi);
        win_lo[l] = lo;
        win_hi[l] = hi;
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0 && ofs_we === 1'b0 && resync === 1'b0
            && rd_req_valid === 1'b0, "R1", "control outputs in reset",
            {27'd0, busy, done, ofs_we, resync, rd_req_valid}, 32'd0);
        chk(ofs_final === 32'd0, "R1", "final word in reset", ofs_final, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && ofs_we === 1'b0 && rd_req_valid === 1'b0, "R1",
            "idle after reset", {29'd0, busy, ofs_we, rd_req_valid}, 32'd0);

        // R3 R4: coarse 0, both limits at 8, every lane passes at 8
        for (int l = 0; l < LANES; l++) set_win(l, 0, 20);
        run_case(0, 1'b0, 0, 1'b0);

        // R4: coarse 0 with nothing passing leaves defaults
        for (int l = 0; l < LANES; l++) set_win(l, 30, 40);
        run_case(0, 1'b1, 2, 1'b0);

        // R3 clamp, R9 truncation toward zero, R2 sign handling
        set_win(0, 120, 200);
        set_win(1, -119, -119);
        set_win(2, -7, -4);
        set_win(3, -1, 0);
        run_case(127, 1'b0, 0, 1'b0);

        // R4: empty windows across a wide sweep, R8 late mismatch
        for (int l = 0; l < LANES; l++) set_win(l, 300, 200);
        run_case(20, 1'b1, 3, 1'b0);

        // R10: start pulses mid-run are ignored
        set_win(0, -3, 5);
        set_win(1, 10, 14);
        set_win(2, 2, 2);
        set_win(3, -12, 30);
        run_case(15, 1'b0, 1, 1'b1);

        // random windows and lock values
        for (int n = 0; n < 8; n++) begin
            for (int l = 0; l < LANES; l++) begin
                int lo;
                lo = $urandom_range(0, 80) - 40;
                if ($urandom_range(0, 4) == 0) set_win(l, 60, 50);
                else set_win(l, lo, lo + $urandom_range(0, 30));
            end
            run_case($urandom_range(0, 30), 1'($urandom_range(0, 1)),
                     $urandom_range(0, 3), 1'b0);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule